// File: doc/BRIEF.md
# Atomic request serialization controller

This block sits between the requesters and the memory side of a cache and makes every atomic read-modify-write behave as a sequentially consistent access. Ordinary loads and stores are accepted at once. When an atomic is accepted, the controller stops taking new requests and holds the atomic's payload in a register. It waits until the counts of outstanding reads and writes are both zero. It then raises a one-cycle issue strobe, so the atomic is the only request in flight. It returns to normal service when the memory side signals that the atomic has completed.

Any ordering hints in the payload are ignored: every atomic is treated as if both acquire and release were requested, so every atomic drains the pipeline in full. A build parameter can turn atomic support off. In that case an atomic is accepted and answered with a one-cycle error strobe, and no draining takes place.

Top module: `amo_serializer`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `busy_o`, `amo_issue_o` and `err_valid_o` are 0.
- R2: With no atomic in progress, `req_ready_o` is 1. A request whose kind is load (2'b00), store (2'b01) or reserved (2'b11) is accepted without changing `busy_o`.
- R3: With `AMO_EN`=1, an accepted atomic (kind 2'b10) makes `busy_o` 1 and `req_ready_o` 0 from the next cycle on.
- R4: While busy and before the issue, `amo_issue_o` stays 0 in any cycle that follows a clock edge at which `rd_pend_i` or `wr_pend_i` was non-zero.
- R5: `amo_issue_o` goes high for exactly one cycle. That cycle follows the first edge in the drain phase at which both counts are zero.
- R6: `amo_data_o` equals the payload captured when the atomic was accepted, and it stays stable until the next atomic is accepted.
- R7: After the issue, the block stays busy until `amo_done_i` is seen high at a clock edge. In the cycle after that edge, `busy_o` is 0 and `req_ready_o` is 1.
- R8: A pulse on `amo_done_i` during the drain phase or during the issue cycle has no effect.
- R9: Payload bits [1:0] carry the acquire and release hints and are ignored. An atomic with both bits 0 still waits for the full drain.
- R10: With `AMO_EN`=0, an accepted atomic raises `err_valid_o` in the next cycle only. `busy_o` stays 0 and `amo_issue_o` never rises.
- R11: With `AMO_EN`=1, `err_valid_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Requester request valid |
| req_kind_i | input | 2 | Request kind: 00 load, 01 store, 10 atomic, 11 reserved |
| req_data_i | input | PAY_W | Request payload; bits [1:0] are ordering hints |
| req_ready_o | output | 1 | Requester may hand over a request |
| rd_pend_i | input | CNT_W | Number of outstanding reads |
| wr_pend_i | input | CNT_W | Number of outstanding writes |
| amo_done_i | input | 1 | Atomic response received from memory |
| amo_issue_o | output | 1 | One-cycle strobe: send held atomic to memory |
| amo_data_o | output | PAY_W | Held atomic payload |
| busy_o | output | 1 | An atomic is draining, issuing or awaiting its response |
| err_valid_o | output | 1 | Error response for an atomic when support is disabled |

## Verification
Suppose the state register wrongly stays idle or leaves the wait state early. Then `req_ready_o` is seen high while an atomic is still unanswered, one cycle after the faulty edge. A wrong drain decision shows up as an issue strobe one cycle after an edge with non-zero counts, or as no strobe one cycle after counts reach zero. The bench checks the cycle just after each such edge. A payload register that loads at the wrong time appears on `amo_data_o` at the issue strobe, where the scoreboard compares it against the queued payload.

// File: rtl/amo_ser_pkg.sv
package amo_ser_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD   = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_ATOMIC = 2'b10,
    KIND_RSVD   = 2'b11
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_DRAIN = 2'b01,
    ST_ISSUE = 2'b10,
    ST_WAIT  = 2'b11
  } ser_state_e;

endpackage

// File: rtl/amo_drain_detect.sv
module amo_drain_detect #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] rd_pend_i,
  input  logic [CNT_W-1:0] wr_pend_i,
  output logic             drained_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  always_comb begin
    drained_o = (rd_pend_i == ZERO) && (wr_pend_i == ZERO);
  end
endmodule

// File: rtl/amo_hold_reg.sv
module amo_hold_reg #(
  parameter int PAY_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PAY_W-1:0] d_i,
  output logic [PAY_W-1:0] q_o
);
  logic [PAY_W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (load_i) q_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  // R6: payload held unless a new atomic is loaded
  a_r6_payload_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/amo_err_gen.sv
module amo_err_gen #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic amo_hs_i,
  output logic err_o
);
  localparam logic REJECT = !ENABLE;
  logic err_d;

  always_comb begin
    err_d = amo_hs_i & REJECT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= err_d;
  end

  // R10: an error strobe only follows an accepted atomic
  a_r10_err_follows_atomic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(amo_hs_i));
  // R11: no error strobe when atomics are supported
  a_r11_no_err_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ENABLE |-> !err_o);
endmodule

// File: rtl/amo_ser_fsm.sv
module amo_ser_fsm
  import amo_ser_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_amo_i,
  input  logic drained_i,
  input  logic amo_done_i,
  output logic req_ready_o,
  output logic amo_issue_o,
  output logic busy_o
);
  ser_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (take_amo_i) state_d = ST_DRAIN;
      ST_DRAIN: if (drained_i)  state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (amo_done_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    req_ready_o = (state_q == ST_IDLE);
    amo_issue_o = (state_q == ST_ISSUE);
    busy_o      = (state_q != ST_IDLE);
  end

  // R3: a taken atomic blocks the requesters on the next cycle
  a_r3_take_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_amo_i |=> (busy_o && !req_ready_o));
  // R4: no issue while anything is still pending
  a_r4_no_early_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && !drained_i) |=> !amo_issue_o);
  // R5: issue only after a drained edge, and for one cycle
  a_r5_issue_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amo_issue_o |-> $past(drained_i));
  a_r5_single_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amo_issue_o |=> !amo_issue_o);
  // R7: remain busy until the response arrives
  a_r7_wait_for_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !amo_done_i) |=> busy_o);
  // R8: a response during the drain is ignored
  a_r8_done_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && amo_done_i) |=> busy_o);
endmodule

// File: rtl/amo_serializer.sv
module amo_serializer
  import amo_ser_pkg::*;
#(
  parameter int PAY_W  = 32,
  parameter int CNT_W  = 4,
  parameter bit AMO_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_kind_i,
  input  logic [PAY_W-1:0] req_data_i,
  output logic             req_ready_o,
  input  logic [CNT_W-1:0] rd_pend_i,
  input  logic [CNT_W-1:0] wr_pend_i,
  input  logic             amo_done_i,
  output logic             amo_issue_o,
  output logic [PAY_W-1:0] amo_data_o,
  output logic             busy_o,
  output logic             err_valid_o
);
  localparam logic SUPPORT = AMO_EN;

  logic amo_hs, take_amo, drained;

  always_comb begin
    amo_hs   = req_valid_i && req_ready_o && (req_kind_i == KIND_ATOMIC);
    take_amo = amo_hs && SUPPORT;
  end

  amo_drain_detect #(.CNT_W(CNT_W)) u_drain (
    .rd_pend_i (rd_pend_i),
    .wr_pend_i (wr_pend_i),
    .drained_o (drained)
  );

  amo_ser_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_amo_i  (take_amo),
    .drained_i   (drained),
    .amo_done_i  (amo_done_i),
    .req_ready_o (req_ready_o),
    .amo_issue_o (amo_issue_o),
    .busy_o      (busy_o)
  );

  amo_hold_reg #(.PAY_W(PAY_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take_amo),
    .d_i    (req_data_i),
    .q_o    (amo_data_o)
  );

  amo_err_gen #(.ENABLE(AMO_EN)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .amo_hs_i (amo_hs),
    .err_o    (err_valid_o)
  );

  // R10: with support off, the block never becomes busy
  a_r10_never_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !SUPPORT |-> (!busy_o && !amo_issue_o));
  // R2: non-atomic traffic never starts the serialization
  a_r2_plain_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(req_valid_i && req_kind_i == KIND_ATOMIC)) |=> !busy_o);
endmodule

// File: tb/sim_amo_serializer.sv
module sim_amo_serializer;
  localparam int PAY_W = 32;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [PAY_W-1:0] req_data = '0;
  logic [CNT_W-1:0] rd_pend = '0;
  logic [CNT_W-1:0] wr_pend = '0;
  logic amo_done = 1'b0;

  logic rdy0, iss0, busy0, err0;
  logic [PAY_W-1:0] dat0;
  logic rdy1, iss1, busy1, err1;
  logic [PAY_W-1:0] dat1;

  int vectors = 0;
  int miscompares = 0;
  logic [PAY_W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  amo_serializer #(.PAY_W(PAY_W), .CNT_W(CNT_W), .AMO_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_data_i(req_data), .req_ready_o(rdy0), .rd_pend_i(rd_pend), .wr_pend_i(wr_pend),
    .amo_done_i(amo_done), .amo_issue_o(iss0), .amo_data_o(dat0), .busy_o(busy0),
    .err_valid_o(err0));

  amo_serializer #(.PAY_W(PAY_W), .CNT_W(CNT_W), .AMO_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_data_i(req_data), .req_ready_o(rdy1), .rd_pend_i(rd_pend), .wr_pend_i(wr_pend),
    .amo_done_i(amo_done), .amo_issue_o(iss1), .amo_data_o(dat1), .busy_o(busy1),
    .err_valid_o(err1));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: one-cycle request; returns at the negedge after the accepting edge
  task automatic send(input logic [1:0] kind, input logic [PAY_W-1:0] pay);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = kind;
    req_data  = pay;
    if (kind == 2'b10) exp_q.push_back(pay);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: every issue strobe pops the scoreboard and compares the payload
  always @(negedge clk) begin
    if (rst_n && iss0) begin
      if (exp_q.size() == 0) chk("R5 unexpected issue", 64'(iss0), 64'h0);
      else chk("R6 issued payload", 64'(dat0), 64'(exp_q.pop_front()));
    end
    if (rst_n) chk("R11 no error when enabled", 64'(err0), 64'h0);
    if (rst_n) chk("R10 disabled never issues", 64'(iss1), 64'h0);
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(rdy0), 64'h1);
    chk("R1 busy", 64'(busy0), 64'h0);
    chk("R1 issue", 64'(iss0), 64'h0);
    chk("R1 err", 64'(err1), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 plain load accepted, no serialization
    send(2'b00, 32'hAAAA_0000);
    chk("R2 load busy", 64'(busy0), 64'h0);
    chk("R2 load ready", 64'(rdy0), 64'h1);

    // Atomic A, ordering bits 00 (R9), with reads pending
    rd_pend = 4'd2;
    send(2'b10, 32'h1234_5670);
    chk("R3 busy", 64'(busy0), 64'h1);
    chk("R3 ready low", 64'(rdy0), 64'h0);
    chk("R10 err strobe", 64'(err1), 64'h1);
    chk("R10 disabled not busy", 64'(busy1), 64'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 R9 hold while reads pending", 64'(iss0), 64'h0);
      chk("R6 payload held", 64'(dat0), 64'h1234_5670);
    end
    chk("R10 err single cycle", 64'(err1), 64'h0);
    rd_pend = 4'd0;
    wr_pend = 4'd1;
    @(negedge clk);
    chk("R4 hold while write pending", 64'(iss0), 64'h0);
    amo_done = 1'b1;
    @(negedge clk);
    amo_done = 1'b0;
    chk("R8 done in drain ignored", 64'(busy0), 64'h1);
    chk("R4 still held", 64'(iss0), 64'h0);
    wr_pend = 4'd0;
    @(negedge clk);
    chk("R5 issue after drain", 64'(iss0), 64'h1);
    @(negedge clk);
    chk("R5 issue one cycle", 64'(iss0), 64'h0);
    chk("R7 busy in wait", 64'(busy0), 64'h1);
    @(negedge clk);
    chk("R7 still waiting", 64'(rdy0), 64'h0);
    amo_done = 1'b1;
    @(negedge clk);
    amo_done = 1'b0;
    chk("R7 idle after done", 64'(busy0), 64'h0);
    chk("R7 ready after done", 64'(rdy0), 64'h1);

    // Atomic B, counts already zero, ordering bits 11
    send(2'b10, 32'hCAFE_BEE3);
    chk("R5 no issue in first drain cycle", 64'(iss0), 64'h0);
    @(negedge clk);
    chk("R5 issue with empty pipeline", 64'(iss0), 64'h1);
    amo_done = 1'b1;
    @(negedge clk);
    amo_done = 1'b0;
    chk("R8 done in issue cycle ignored", 64'(busy0), 64'h1);
    chk("R6 payload B", 64'(dat0), 64'hCAFE_BEE3);
    @(negedge clk);
    amo_done = 1'b1;
    @(negedge clk);
    amo_done = 1'b0;
    chk("R7 idle after B", 64'(busy0), 64'h0);

    // Store and reserved kinds
    send(2'b01, 32'h5555_0001);
    chk("R2 store busy", 64'(busy0), 64'h0);
    chk("R10 store no err", 64'(err1), 64'h0);
    chk("R6 payload kept after store", 64'(dat0), 64'hCAFE_BEE3);
    send(2'b11, 32'h7777_0002);
    chk("R2 reserved busy", 64'(busy0), 64'h0);
    chk("R2 reserved ready", 64'(rdy0), 64'h1);

    repeat (2) @(negedge clk);
    chk("R5 all atomics issued", 64'(exp_q.size()), 64'h0);
    summary();
  end
endmodule